// File: doc/BRIEF.md
# Multi-Channel Synchronized PWM Generator

This block drives a bank of pulse-width-modulated outputs, four by default, from one clock. Each channel is described by three 32-bit numbers: a period, a high time and a phase offset, all counted in clock cycles. A host programs the block through a simple 32-bit register port. The port accepts a write in the cycle it is presented and returns read data one cycle after a read request.

Channel settings written by the host land in shadow registers. The waveform keeps running on the previously committed values until the host issues a single load command. That command commits the shadow values of every channel in the same clock edge and restarts every channel counter at zero. Channels whose periods are integer multiples of one another therefore stay phase-aligned after each update.

A hold bit keeps the whole bank quiet, with all outputs low and all counters at zero. The hold bit is set when the block leaves power-on reset, so the host has to clear it to start the bank. Identification, version, scratch and channel-count registers let software confirm the block before it uses it.

Top module: `pwm_sync_bank`

## Requirements
- R1: After reset, the configuration register at 0x10 reads 1 (hold set), the scratch register and every channel register read 0, and every output is low.
- R2: Reads return data in the cycle after `rd_en` is sampled. Address 0x00 reads the version word: major 1 in bits 31:16, minor in bits 15:8, patch in bits 7:0 (0x00010200 by default). 0x04 reads the identifier parameter (0x00000A55 by default). 0x0C reads 0x601A3471. 0x14 reads the channel count.
- R3: The scratch register at 0x08 reads back the last value written to it.
- R4: Writes to 0x00, 0x04, 0x0C and 0x14 are ignored. Writes to addresses that are unmapped or not word-aligned change nothing. Reads of such addresses return 0.
- R5: Configuration bit 0 is hold. While hold is 1, every output is low and every counter is held at zero. After hold is cleared, counting starts from zero.
- R6: Writing 1 to configuration bit 1 issues the load command. This bit is self-clearing, so a read of 0x10 returns only the hold bit in bit 0, with bits 31:1 reading 0.
- R7: The registers of channel ch sit at byte addresses 0x40+12*ch (period), 0x44+12*ch (high time) and 0x48+12*ch (offset). Reads return the last value written (the shadow), not the committed value.
- R8: Writing a channel register does not change any output until the next load command. The previously committed values keep generating the waveform.
- R9: The load command commits the shadow values of every channel at once and restarts every counter at zero on the same edge, cutting short the running period.
- R10: An enabled channel counts 0 to period-1 and wraps. Its output is high while offset <= count < offset+high time, with the sum taken without overflow.
- R11: A high time of 0 gives a constant low output. A high time equal to or greater than the period gives a constant high output, whatever the offset.
- R12: A channel whose committed period is 0 is disabled. Its output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, accepted in the cycle it is high |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, valid the cycle after rd_en; holds otherwise |
| pwm_out | output | NCH | One active-high PWM output per channel |

## Verification
The bench tries several channel settings side by side, and each setting separates a different mistake:
- A plain pulse at offset 0, and a pulse delayed by an offset inside the period, expose errors in the compare window.
- An offset beyond the period, and a window that runs past the wrap, separate a correct comparison from a modular one.
- High times of zero and above the period probe the two saturating cases.
- A zero period probes the disable path.

Shadow registers are rewritten and then left uncommitted for several periods, which tells apart a design that commits at once from one that waits for the load. The load command is issued in the middle of running periods to show that all counters restart together. Hold is raised and released mid-waveform, and a load is issued while hold is set.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  localparam int REG_W = 32;

  localparam int A_VERSION = 'h00;
  localparam int A_IDENT   = 'h04;
  localparam int A_SCRATCH = 'h08;
  localparam int A_MAGIC   = 'h0C;
  localparam int A_CONFIG  = 'h10;
  localparam int A_COUNT   = 'h14;
  localparam int A_CH_BASE = 'h40;
  localparam int CH_STRIDE = 12;

  localparam int F_PERIOD = 0;
  localparam int F_HIGH   = 1;
  localparam int F_OFFSET = 2;

  localparam logic [REG_W-1:0] MAGIC_WORD = 32'h601A_3471;

  typedef struct packed {
    logic [REG_W-1:0] period;
    logic [REG_W-1:0] high;
    logic [REG_W-1:0] offset;
  } chan_cfg_t;

  // Byte address of one field of one channel.
  function automatic int chan_addr(int ch, int fld);
    return A_CH_BASE + CH_STRIDE * ch + 4 * fld;
  endfunction

  // Output level of a channel for a given count and committed settings.
  function automatic logic pulse_level(logic [REG_W-1:0] cnt,
                                       logic [REG_W-1:0] period,
                                       logic [REG_W-1:0] high,
                                       logic [REG_W-1:0] offset);
    logic [REG_W:0] win_end;
    win_end = {1'b0, offset} + {1'b0, high};
    if (period == '0) return 1'b0;
    if (high >= period) return 1'b1;
    return (cnt >= offset) && ({1'b0, cnt} < win_end);
  endfunction

endpackage

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs
  import pwm_sync_pkg::*;
#(
  parameter int          NCH       = 4,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CORE_ID   = 32'h0000_0A55,
  parameter logic [7:0]  VER_MINOR = 8'd2,
  parameter logic [7:0]  VER_PATCH = 8'd0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  output logic                    hold_q,
  output logic                    load_evt,
  output chan_cfg_t [NCH-1:0]     shadow
);

  localparam logic [REG_W-1:0] VERSION_WORD = {16'd1, VER_MINOR, VER_PATCH};

  logic [REG_W-1:0] scratch_q;
  logic [REG_W-1:0] rd_next;
  logic             cfg_hit;

  assign cfg_hit  = wr_en && (wr_addr == ADDR_W'(A_CONFIG));
  assign load_evt = cfg_hit && wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b1;
      scratch_q <= '0;
    end else begin
      if (cfg_hit) hold_q <= wr_data[0];
      if (wr_en && (wr_addr == ADDR_W'(A_SCRATCH))) scratch_q <= wr_data;
    end
  end

  // Shadow copies of every channel's settings.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == ADDR_W'(chan_addr(c, F_PERIOD))) shadow[c].period <= wr_data;
        if (wr_addr == ADDR_W'(chan_addr(c, F_HIGH)))   shadow[c].high   <= wr_data;
        if (wr_addr == ADDR_W'(chan_addr(c, F_OFFSET))) shadow[c].offset <= wr_data;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      ADDR_W'(A_VERSION): rd_next = VERSION_WORD;
      ADDR_W'(A_IDENT):   rd_next = CORE_ID;
      ADDR_W'(A_SCRATCH): rd_next = scratch_q;
      ADDR_W'(A_MAGIC):   rd_next = MAGIC_WORD;
      ADDR_W'(A_CONFIG):  rd_next = {{(REG_W-1){1'b0}}, hold_q};
      ADDR_W'(A_COUNT):   rd_next = REG_W'(NCH);
      default:            rd_next = '0;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == ADDR_W'(chan_addr(c, F_PERIOD))) rd_next = shadow[c].period;
      if (rd_addr == ADDR_W'(chan_addr(c, F_HIGH)))   rd_next = shadow[c].high;
      if (rd_addr == ADDR_W'(chan_addr(c, F_OFFSET))) rd_next = shadow[c].offset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/pwm_sync_chan.sv
module pwm_sync_chan
  import pwm_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      load,
  input  chan_cfg_t shadow,
  output logic      pwm,
  output logic      en,
  output logic      cnt_zero
);

  chan_cfg_t        act_q;
  logic [REG_W-1:0] cnt_q;
  logic             at_wrap;

  assign en       = (act_q.period != '0);
  assign at_wrap  = (cnt_q == act_q.period - 1'b1);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) act_q <= shadow;
      if (load || hold || !en || at_wrap) cnt_q <= '0;
      else                                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm = !hold && pulse_level(cnt_q, act_q.period, act_q.high, act_q.offset);

endmodule

// File: rtl/pwm_sync_bank.sv
module pwm_sync_bank
  import pwm_sync_pkg::*;
#(
  parameter int          NCH       = 4,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CORE_ID   = 32'h0000_0A55,
  parameter logic [7:0]  VER_MINOR = 8'd2,
  parameter logic [7:0]  VER_PATCH = 8'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NCH-1:0]    pwm_out
);

  // Named internal events, brought out for the checker.
  logic                hold_q;
  logic                load_evt;
  logic [NCH-1:0]      ch_en;
  logic [NCH-1:0]      cnt_zero;
  chan_cfg_t [NCH-1:0] shadow;

  pwm_sync_regs #(
    .NCH(NCH), .ADDR_W(ADDR_W), .CORE_ID(CORE_ID),
    .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hold_q(hold_q), .load_evt(load_evt), .shadow(shadow)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_sync_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .hold(hold_q), .load(load_evt), .shadow(shadow[g]),
      .pwm(pwm_out[g]), .en(ch_en[g]), .cnt_zero(cnt_zero[g])
    );
  end

endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk
  import pwm_sync_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    cnt_zero,
  input logic              hold_q,
  input logic              load_evt
);

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (pwm_out == '0));

  p_hold_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (&cnt_zero));

  p_disabled_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~ch_en) == '0);

  p_commit_only_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(ch_en));

  p_load_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (&cnt_zero));

  p_cfg_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(A_CONFIG)) |=> (rd_data[31:1] == '0));

  p_magic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(A_MAGIC)) |=> (rd_data == MAGIC_WORD));

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(A_COUNT)) |=> (rd_data == 32'(NCH)));

endmodule

bind pwm_sync_bank pwm_sync_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .pwm_out(pwm_out), .ch_en(ch_en), .cnt_zero(cnt_zero),
  .hold_q(hold_q), .load_evt(load_evt)
);

// File: tb/pwm_sync_bank_tb.sv
module pwm_sync_bank_tb;

  localparam int NCH = 4;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  wire  [31:0]   rd_data;
  wire  [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  pwm_sync_bank #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  // Behavioural reference: shadow and committed settings, one counter each.
  longint sh_p[NCH], sh_h[NCH], sh_o[NCH];
  longint ac_p[NCH], ac_h[NCH], ac_o[NCH];
  longint cnt[NCH];
  bit     m_hold;

  function automatic int reg_of(int ch, int fld);
    return 64 + ch * 12 + fld * 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 1;
      for (int c = 0; c < NCH; c++) begin
        sh_p[c] = 0; sh_h[c] = 0; sh_o[c] = 0;
        ac_p[c] = 0; ac_h[c] = 0; ac_o[c] = 0; cnt[c] = 0;
      end
    end else begin
      bit ld;
      ld = wr_en && wr_addr == 8'h10 && wr_data[1];
      for (int c = 0; c < NCH; c++) begin
        if (ld) begin
          ac_p[c] = sh_p[c]; ac_h[c] = sh_h[c]; ac_o[c] = sh_o[c]; cnt[c] = 0;
        end else if (m_hold || ac_p[c] == 0) cnt[c] = 0;
        else begin
          cnt[c] = cnt[c] + 1;
          if (cnt[c] >= ac_p[c]) cnt[c] = 0;
        end
      end
      if (wr_en) begin
        if (wr_addr == 8'h10) m_hold = wr_data[0];
        for (int c = 0; c < NCH; c++) begin
          if (int'(wr_addr) == reg_of(c, 0)) sh_p[c] = longint'(wr_data);
          if (int'(wr_addr) == reg_of(c, 1)) sh_h[c] = longint'(wr_data);
          if (int'(wr_addr) == reg_of(c, 2)) sh_o[c] = longint'(wr_data);
        end
      end
    end
  end

  function automatic bit want_level(int c);
    if (m_hold) return 0;
    if (ac_p[c] == 0) return 0;
    if (ac_h[c] >= ac_p[c]) return 1;
    if (cnt[c] < ac_o[c]) return 0;
    return (cnt[c] - ac_o[c]) < ac_h[c];
  endfunction

  // Compare every output on every clock, away from the active edge.
  // R1 (low in reset), R5, R8, R9, R10, R11, R12.
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        bit e;
        e = rst_n ? want_level(c) : 1'b0;
        n_chk++;
        if (pwm_out[c] !== e) begin
          n_bad++;
          $display("FAIL R8/R9/R10/R11/R12 ch%0d t=%0t pwm_out=%0b expected=%0b",
                   c, $time, pwm_out[c], e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a[AW-1:0];
    @(negedge clk);
    rd_en = 1'b0;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s addr=0x%02h rd_data=0x%08h expected=0x%08h", req, a, rd_data, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input logic [31:0] p, input logic [31:0] h,
                        input logic [31:0] o);
    wr(reg_of(c, 0), p);
    wr(reg_of(c, 1), h);
    wr(reg_of(c, 2), o);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(4);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state.
    rd_chk('h10, 32'h1, "R1");
    rd_chk('h08, 32'h0, "R1");
    for (int c = 0; c < NCH; c++) rd_chk(reg_of(c, 0), 32'h0, "R1");

    // R2: identification.
    rd_chk('h00, 32'h0001_0200, "R2");
    rd_chk('h04, 32'h0000_0A55, "R2");
    rd_chk('h0C, 32'h601A_3471, "R2");
    rd_chk('h14, 32'd4, "R2");

    // R3: scratch.
    wr('h08, 32'hDEAD_BEEF);
    rd_chk('h08, 32'hDEAD_BEEF, "R3");
    wr('h08, 32'h1234_5678);
    rd_chk('h08, 32'h1234_5678, "R3");

    // R4: read-only, unmapped and unaligned addresses.
    wr('h00, 32'hFFFF_FFFF); wr('h04, 32'hFFFF_FFFF);
    wr('h0C, 32'h0);         wr('h14, 32'h99);
    wr('h18, 32'hAAAA_AAAA); wr('h41, 32'h55);
    rd_chk('h00, 32'h0001_0200, "R4");
    rd_chk('h04, 32'h0000_0A55, "R4");
    rd_chk('h0C, 32'h601A_3471, "R4");
    rd_chk('h14, 32'd4, "R4");
    rd_chk('h08, 32'h1234_5678, "R4");
    rd_chk('h18, 32'h0, "R4");
    rd_chk('h3C, 32'h0, "R4");
    rd_chk('h42, 32'h0, "R4");
    rd_chk('h70, 32'h0, "R4");
    rd_chk('hFC, 32'h0, "R4");
    rd_chk(reg_of(0, 0), 32'h0, "R4");

    // R7: channel layout and shadow read-back.
    set_ch(0, 10, 3, 0);
    set_ch(1, 20, 5, 7);
    set_ch(2, 5, 5, 2);
    set_ch(3, 0, 4, 0);
    rd_chk(reg_of(0, 0), 32'd10, "R7");
    rd_chk(reg_of(1, 1), 32'd5, "R7");
    rd_chk(reg_of(1, 2), 32'd7, "R7");
    rd_chk(reg_of(2, 0), 32'd5, "R7");
    rd_chk(reg_of(3, 1), 32'd4, "R7");

    // R8: release hold without load; committed values still zero.
    wr('h10, 32'h0);
    idle(20);

    // R9: load commits all channels; R10, R11 and R12 by per-cycle compare.
    wr('h10, 32'h2);
    rd_chk('h10, 32'h0, "R6");
    idle(60);

    // R8: new shadows stay idle for several periods.
    set_ch(0, 7, 2, 4);
    rd_chk(reg_of(0, 0), 32'd7, "R7");
    idle(25);
    wr('h10, 32'h2);
    idle(50);

    // R11: zero high time and high time above the period.
    wr(reg_of(2, 1), 32'd0);
    set_ch(3, 6, 9, 3);
    idle(7);
    wr('h10, 32'h2);
    idle(40);

    // R5: hold mid-waveform, then release.
    idle(3);
    wr('h10, 32'h1);
    idle(10);
    rd_chk('h10, 32'h1, "R5");
    wr('h10, 32'h0);
    idle(40);

    // R10: offset beyond period, and a window past the wrap.
    set_ch(1, 8, 3, 9);
    set_ch(0, 10, 5, 7);
    wr('h10, 32'h2);
    idle(45);

    // R9: load while hold is set commits but keeps outputs low.
    set_ch(3, 0, 1, 0);
    wr('h10, 32'h3);
    idle(10);
    rd_chk('h10, 32'h1, "R6");
    wr('h10, 32'h0);
    idle(40);

    finish_run();
  end

endmodule